// File: doc/BRIEF.md
# Optimistic Epoch Conflict Tracker

A near-memory accelerator can run a kernel optimistically while the host CPU keeps running. During that time it sends no coherence traffic to the host. This block watches three address streams: accelerator reads, accelerator writes and CPU writes. It folds each cache-line address into one of three small hashed signatures.

When the epoch closes, the block compares the CPU-write signature with the accelerator-read signature. It then gives a single verdict. Commit means the work stands and the per-line uncommitted marks may be cleared. Re-execute means every uncommitted accelerator update must be invalidated and the uncommitted part of the kernel run again.

The accelerator-write signature is handed out in the verdict cycle, so the host side can perform its coherence work on the touched lines. The block is used as a passive observer beside the accelerator's L1. The controller opens an epoch, streams traffic past the block, closes the epoch, and acts on the verdict pulse two cycles later.

Top module: `optim_sig_tracker`

## Requirements
- R1: After reset, commit, reexec, clr_uncommitted and invalidate are 0, epoch_open is 0 and acc_wr_sig is all zero.
- R2: epoch_start while no epoch is in progress opens an epoch. epoch_open reads 1 from the next cycle, and the observations in the epoch_start cycle itself are recorded.
- R3: Observations arriving while no epoch is open (and epoch_start is low) are not recorded and cannot influence any later verdict.
- R4: Each signature has two banks of 256 bits, and a valid address sets one bit in each bank. The line number is addr[31:6]. It is split into 8-bit chunks c0..c3 (c0 = bits 7:0, with the missing top bits of c3 read as zero). Bank k gets index XOR over i of rotate-left(ci, k*i mod 8).
- R5: The verdict is reexec when, in both banks, the CPU-write signature and the accelerator-read signature have at least one set bit in common. Otherwise it is commit.
- R6: A CPU write and an accelerator read to the same cache line within one epoch always produce reexec (no false negatives).
- R7: If epoch_end is seen in cycle T of an open epoch, exactly one of commit or reexec is high in cycle T+2, for that cycle only, and both are low in T+1 and T+3.
- R8: clr_uncommitted pulses together with commit, and invalidate pulses together with reexec.
- R9: Addresses presented in the same cycle as epoch_end belong to the closing epoch.
- R10: All three signatures are cleared at the end of the verdict cycle. epoch_open is 0 from T+1 on, and the next epoch starts with empty signatures.
- R11: acc_wr_sig carries the accelerator-write signature during the verdict cycle and is zero otherwise. Bank k occupies bits [k*256 +: 256].
- R12: epoch_end with no epoch open produces no verdict, and epoch_start during an open epoch neither restarts it nor clears any signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd_vld | input | 1 | Accelerator read observed |
| acc_rd_addr | input | 32 | Accelerator read byte address |
| acc_wr_vld | input | 1 | Accelerator write observed |
| acc_wr_addr | input | 32 | Accelerator write byte address |
| cpu_wr_vld | input | 1 | CPU write observed |
| cpu_wr_addr | input | 32 | CPU write byte address |
| epoch_start | input | 1 | Open an optimistic epoch |
| epoch_end | input | 1 | Close the current epoch |
| epoch_open | output | 1 | An epoch is recording |
| commit | output | 1 | One-cycle commit verdict |
| reexec | output | 1 | One-cycle re-execute verdict |
| clr_uncommitted | output | 1 | Strobe to clear uncommitted line flags |
| invalidate | output | 1 | Strobe to drop uncommitted accelerator lines |
| acc_wr_sig | output | 512 | Accelerator-write signature, valid in the verdict cycle |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 64-byte lines, two hash banks of 256 bits. With these values the line number fits in four 8-bit chunks, so the bench can derive every bank index from its own rotate-and-fold function. Random addresses are drawn mostly from 16 lines, which makes shared lines, and with them both verdicts, frequent. The occasional fully random address exercises the upper chunks and aliasing in the filters.

// File: rtl/sigtrk_pkg.sv
package sigtrk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_RESOLVE = 2'd2,
        ST_VERDICT = 2'd3
    } trk_state_t;

    typedef struct packed {
        logic commit;
        logic reexec;
    } verdict_t;

    // Fold a line number into an index: bit b of the line lands in chunk
    // b/idx_w at position b%idx_w, rotated left by k*chunk.
    function automatic logic [15:0] fold_hash(input logic [63:0] line,
                                              input int line_w,
                                              input int idx_w,
                                              input int k);
        logic [15:0] h;
        h = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < line_w) begin
                int ch;
                int pos;
                ch  = b / idx_w;
                pos = ((b % idx_w) + k * ch) % idx_w;
                h[pos] = h[pos] ^ line[b];
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/sig_bank.sv
module sig_bank
    import sigtrk_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 6,
    parameter int NHASH    = 2,
    parameter int BANK_W   = 256
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    ins,
    input  logic [ADDR_W-1:0]       addr,
    output logic [NHASH*BANK_W-1:0] bits
);
    localparam int LINE_W = ADDR_W - LINE_OFF;
    localparam int IDX_W  = $clog2(BANK_W);

    logic [63:0] line;

    always_comb begin
        line = '0;
        line[LINE_W-1:0] = addr[ADDR_W-1:LINE_OFF];
    end

    for (genvar k = 0; k < NHASH; k++) begin : g_bank
        logic [15:0]       h;
        logic [IDX_W-1:0]  idx;
        logic [BANK_W-1:0] q;

        always_comb begin
            h   = fold_hash(line, LINE_W, IDX_W, k);
            idx = h[IDX_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst || clr)
                q <= '0;
            else if (ins)
                q[idx] <= 1'b1;
        end

        assign bits[k*BANK_W +: BANK_W] = q;
    end

    // R10
    sig_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bits == '0));

endmodule

// File: rtl/conflict_detect.sv
module conflict_detect #(
    parameter int NHASH  = 2,
    parameter int BANK_W = 256
) (
    input  logic [NHASH*BANK_W-1:0] cpu_wr_sig,
    input  logic [NHASH*BANK_W-1:0] acc_rd_sig,
    output logic                    violation
);
    logic [NHASH-1:0] bank_hit;

    for (genvar k = 0; k < NHASH; k++) begin : g_cmp
        assign bank_hit[k] = |(cpu_wr_sig[k*BANK_W +: BANK_W] &
                               acc_rd_sig[k*BANK_W +: BANK_W]);
    end

    assign violation = &bank_hit;

endmodule

// File: rtl/optim_sig_tracker.sv
module optim_sig_tracker
    import sigtrk_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 6,
    parameter int SIG_BITS = 512,
    parameter int NHASH    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_rd_vld,
    input  logic [ADDR_W-1:0]   acc_rd_addr,
    input  logic                acc_wr_vld,
    input  logic [ADDR_W-1:0]   acc_wr_addr,
    input  logic                cpu_wr_vld,
    input  logic [ADDR_W-1:0]   cpu_wr_addr,
    input  logic                epoch_start,
    input  logic                epoch_end,
    output logic                epoch_open,
    output logic                commit,
    output logic                reexec,
    output logic                clr_uncommitted,
    output logic                invalidate,
    output logic [SIG_BITS-1:0] acc_wr_sig
);
    localparam int BANK_W = SIG_BITS / NHASH;
    localparam int NSIG   = 3;

    trk_state_t  state, state_nx;
    verdict_t    vq;
    logic        rec, clr, violation;

    logic [NSIG-1:0]             ins_v;
    logic [NSIG-1:0][ADDR_W-1:0] ins_a;
    logic [NSIG-1:0][SIG_BITS-1:0] sig;

    // index 0: accelerator read, 1: accelerator write, 2: CPU write
    assign ins_v = {cpu_wr_vld, acc_wr_vld, acc_rd_vld};
    assign ins_a = {cpu_wr_addr, acc_wr_addr, acc_rd_addr};

    assign rec = (state == ST_RUN) || (state == ST_IDLE && epoch_start);
    assign clr = (state == ST_VERDICT);

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        sig_bank #(
            .ADDR_W  (ADDR_W),
            .LINE_OFF(LINE_OFF),
            .NHASH   (NHASH),
            .BANK_W  (BANK_W)
        ) u_sig (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .ins (rec && ins_v[s]),
            .addr(ins_a[s]),
            .bits(sig[s])
        );
    end

    conflict_detect #(
        .NHASH (NHASH),
        .BANK_W(BANK_W)
    ) u_cmp (
        .cpu_wr_sig(sig[2]),
        .acc_rd_sig(sig[0]),
        .violation (violation)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (epoch_start) state_nx = ST_RUN;
            ST_RUN:     if (epoch_end)   state_nx = ST_RESOLVE;
            ST_RESOLVE: state_nx = ST_VERDICT;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            vq    <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RESOLVE) begin
                vq.commit <= !violation;
                vq.reexec <= violation;
            end else begin
                vq <= '0;
            end
        end
    end

    assign epoch_open      = (state == ST_RUN);
    assign commit          = vq.commit;
    assign reexec          = vq.reexec;
    assign clr_uncommitted = vq.commit;
    assign invalidate      = vq.reexec;
    assign acc_wr_sig      = clr ? sig[1] : '0;

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit && reexec));

    // R7
    verdict_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && epoch_end) |-> ##2 (commit || reexec));

    // R7
    verdict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (commit || reexec) |=> !(commit || reexec));

    // R3
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !epoch_start) |=> $stable(sig));

    // R12
    restart_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (epoch_open && !epoch_end) |=> epoch_open);

endmodule

// File: tb/tb_optim_sig_tracker.sv
module tb_optim_sig_tracker;

    logic         clk = 1'b0;
    logic         rst;
    logic         ar_v, aw_v, cw_v, e_start, e_end;
    logic [31:0]  ar_a, aw_a, cw_a;
    logic         epoch_open, commit, reexec, clr_uncommitted, invalidate;
    logic [511:0] acc_wr_sig;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [511:0] m_ar, m_aw, m_cw;
    bit           m_open;

    always #4 clk = ~clk;

    optim_sig_tracker dut (
        .clk(clk), .rst(rst),
        .acc_rd_vld(ar_v), .acc_rd_addr(ar_a),
        .acc_wr_vld(aw_v), .acc_wr_addr(aw_a),
        .cpu_wr_vld(cw_v), .cpu_wr_addr(cw_a),
        .epoch_start(e_start), .epoch_end(e_end),
        .epoch_open(epoch_open), .commit(commit), .reexec(reexec),
        .clr_uncommitted(clr_uncommitted), .invalidate(invalidate),
        .acc_wr_sig(acc_wr_sig)
    );

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int r);
        return 8'((v << r) | (v >> (8 - r)));
    endfunction

    function automatic int bidx(input logic [31:0] a, input int k);
        logic [25:0] ln;
        logic [7:0]  acc;
        ln  = a[31:6];
        acc = '0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] c;
            c   = 8'((ln >> (8 * i)) & 26'hFF);
            acc = acc ^ rotl8(c, (k * i) % 8);
        end
        return k * 256 + int'(acc);
    endfunction

    function automatic bit m_violation();
        bit h0, h1;
        h0 = |(m_ar[255:0]   & m_cw[255:0]);
        h1 = |(m_ar[511:256] & m_cw[511:256]);
        return h0 && h1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        ar_v = 0; aw_v = 0; cw_v = 0; e_start = 0; e_end = 0;
        ar_a = '0; aw_a = '0; cw_a = '0;
    endtask

    // apply one cycle of stimulus at a negedge, update model, move on
    task automatic step(input bit rv, input logic [31:0] ra,
                        input bit wv, input logic [31:0] wa,
                        input bit cv, input logic [31:0] ca,
                        input bit st, input bit en);
        ar_v = rv; ar_a = ra; aw_v = wv; aw_a = wa;
        cw_v = cv; cw_a = ca; e_start = st; e_end = en;
        if (m_open || st) begin
            if (rv) begin m_ar[bidx(ra, 0)] = 1; m_ar[bidx(ra, 1)] = 1; end
            if (wv) begin m_aw[bidx(wa, 0)] = 1; m_aw[bidx(wa, 1)] = 1; end
            if (cv) begin m_cw[bidx(ca, 0)] = 1; m_cw[bidx(ca, 1)] = 1; end
        end
        if (!m_open && st) m_open = 1;
        @(negedge clk);
    endtask

    // epoch_end cycle, then verdict checks in T+1, T+2, T+3
    task automatic close_epoch(input bit rv, input logic [31:0] ra,
                               input bit wv, input logic [31:0] wa,
                               input bit cv, input logic [31:0] ca,
                               input string req);
        bit exp_re;
        step(rv, ra, wv, wa, cv, ca, 0, 1);
        exp_re = m_violation();
        idle_in();
        chk(!commit && !reexec, "R7", "no verdict in T+1",
            {510'd0, commit, reexec}, 512'd0);
        chk(!epoch_open, "R10", "epoch_open low after end", epoch_open, 0);
        @(negedge clk);
        chk(reexec == exp_re && commit == !exp_re, req, "verdict in T+2",
            {510'd0, commit, reexec}, {510'd0, !exp_re, exp_re});
        chk(clr_uncommitted == commit && invalidate == reexec, "R8", "strobes",
            {510'd0, clr_uncommitted, invalidate}, {510'd0, commit, reexec});
        chk(acc_wr_sig == m_aw, "R11", "write signature handed out",
            acc_wr_sig, m_aw);
        @(negedge clk);
        chk(!commit && !reexec && acc_wr_sig == '0, "R7", "pulse gone in T+3",
            {acc_wr_sig[509:0], commit, reexec}, 512'd0);
        m_ar = '0; m_aw = '0; m_cw = '0; m_open = 0;
    endtask

    function automatic logic [31:0] rnd_addr();
        if ($urandom_range(0, 9) == 0) return $urandom;
        return (32'($urandom_range(0, 15)) << 6) | 32'($urandom_range(0, 63));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'h5EED_0042));
        m_ar = '0; m_aw = '0; m_cw = '0; m_open = 0;
        idle_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1
        chk(!commit && !reexec && !clr_uncommitted && !invalidate && !epoch_open,
            "R1", "reset outputs", {507'd0, commit, reexec, clr_uncommitted,
            invalidate, epoch_open}, 512'd0);
        chk(acc_wr_sig == '0, "R1", "reset signature", acc_wr_sig, 512'd0);

        // R12: epoch_end while idle gives nothing
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle_in();
        for (int i = 0; i < 3; i++) begin
            chk(!commit && !reexec, "R12", "no verdict without epoch",
                {510'd0, commit, reexec}, 512'd0);
            @(negedge clk);
        end

        // R3: conflicting traffic while idle is dropped
        a = 32'h0000_1240;
        step(1, a, 1, a, 1, a, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        chk(epoch_open, "R2", "epoch_open after start", epoch_open, 1);
        close_epoch(0, 0, 0, 0, 0, 0, "R3");

        // R2/R6: read on start cycle, CPU write to same line later
        a = 32'h00AB_CD00;
        step(1, a, 0, 0, 0, 0, 1, 0);
        step(0, 0, 1, 32'h0000_7000, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, a | 32'h3F, 1, 0);   // R12: stray start ignored
        chk(epoch_open, "R12", "start during epoch keeps it open", epoch_open, 1);
        close_epoch(0, 0, 0, 0, 0, 0, "R6");

        // R9: conflicting CPU write in the epoch_end cycle
        b = 32'h1234_5680;
        step(0, 0, 0, 0, 0, 0, 1, 0);
        step(1, b, 0, 0, 0, 0, 0, 0);
        close_epoch(0, 0, 0, 0, 1, b, "R9");

        // R10: fresh epoch with read only to b commits
        step(1, b, 0, 0, 0, 0, 1, 0);
        close_epoch(0, 0, 1, b, 0, 0, "R10");

        // random epochs: R4/R5 against the bench model
        for (int ep = 0; ep < 60; ep++) begin
            int len;
            len = $urandom_range(1, 12);
            step($urandom_range(0, 1), rnd_addr(), $urandom_range(0, 1),
                 rnd_addr(), $urandom_range(0, 1), rnd_addr(), 1, 0);
            for (int c = 0; c < len; c++)
                step($urandom_range(0, 1), rnd_addr(), $urandom_range(0, 1),
                     rnd_addr(), ($urandom_range(0, 3) == 0), rnd_addr(),
                     ($urandom_range(0, 7) == 0), 0);
            close_epoch($urandom_range(0, 1), rnd_addr(), $urandom_range(0, 1),
                        rnd_addr(), $urandom_range(0, 1), rnd_addr(), "R5");
            if ($urandom_range(0, 3) == 0) begin
                step(1, rnd_addr(), 1, rnd_addr(), 1, rnd_addr(), 0, 0);
                idle_in();
            end
        end

        // R4: single write sets exactly bank indices from the hash rule
        a = 32'hFFFF_FFC0;
        step(0, 0, 1, a, 0, 0, 1, 0);
        close_epoch(0, 0, 0, 0, 0, 0, "R4");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule